// File: doc/BRIEF.md
# Dual-Channel Timestamp Capture and Event Interrupt Unit

This block captures the value of a free-running 64-bit time base when an external trigger rises. It has two independent trigger channels. Each trigger is synchronised into the clock domain. On its rising edge the current time value is stored in that channel's queue. Software drains each queue through a small word-wide register port. It reads the lower 32 bits first. Reading the upper 32 bits then retires the entry. A status register shows which channels hold data and which have lost a capture.

Capture events and a pulse-per-second input set bits in an event register. Each event bit is gated by a mask bit, and together they drive one interrupt line. Event bits clear when software writes a 1 to them. An arm register enables a source atomically: it discards any stale pending event for that source and unmasks it in the same write. A build parameter selects between two storage variants. One is a queue per channel. The other is a single holding register per channel that keeps the most recent capture.

Top module: `tsc_capture_top`

## Requirements
- R1: After reset the event (addr 0), mask (addr 1) and status (addr 2) registers read 0, irq_o is low and rdata_o is 0.
- R2: A rising edge on trig_i[c] passes a 2-flop synchroniser and stores time_i in channel c. It also sets event bit c (bit 0 = channel 0, bit 1 = channel 1). A trigger held high captures only once.
- R3: In queue mode each channel holds DEPTH (4) entries. A capture that arrives while the queue is full is dropped and sets overflow status bit 4+c. Writing 1 to that bit clears it.
- R4: Reading addr 4+2c returns bits 31:0 of the oldest entry of channel c without removing it. Reading addr 5+2c returns bits 63:32 and removes that entry. Entries come out in capture order.
- R5: Status bit c is 1 exactly when channel c holds at least one unread entry.
- R6: A high cycle on pps_i sets event bit 2.
- R7: irq_o is high whenever any event bit is set while the mask bit at the same position (addr 1, bits 2:0) is also set.
- R8: Writing the event register clears each bit written as 1 and leaves each bit written as 0 unchanged. A new event in the same cycle wins over the clear.
- R9: Writing 1 to bit k of the arm register (addr 3) clears pending event bit k and sets mask bit k in the same cycle.
- R10: With FIFO_EN=0 each channel keeps only its newest capture. Reading its upper word clears the valid status bit, and no overflow is ever reported.
- R11: Read data appears on rdata_o in the cycle after the read request. It is 0 in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | 64 | Current time base value |
| trig_i | input | 2 | Asynchronous capture triggers, one per channel |
| pps_i | input | 1 | Pulse-per-second event, one clock high |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt, OR of masked events |

## Verification
The hardest states to reach are a full queue that then receives a further trigger, and a capture that lands in the same window as an arm write. The bench reaches them by holding time_i at a distinct value for each trigger. It fires five triggers on one channel without draining it, so the dropped entry can be named by its value. It also leaves a capture pending while its channel is masked and then arms that source, which shows the stale event is discarded and a later trigger still interrupts. A second instance built as the single-register variant shares the stimulus. Its newest-wins behaviour is compared against the queued instance.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int NCH   = 2;
  localparam int NEVT  = 3;
  localparam int EVT_PPS = 2;

  typedef enum logic [2:0] {
    A_EVT   = 3'd0,
    A_MASK  = 3'd1,
    A_STAT  = 3'd2,
    A_ARM   = 3'd3,
    A_C0_LO = 3'd4,
    A_C0_HI = 3'd5,
    A_C1_LO = 3'd6,
    A_C1_HI = 3'd7
  } reg_addr_e;

  localparam int STAT_OVF_LSB = 4;
endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], async_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tsc_store.sv
module tsc_store #(
  parameter int TW      = 64,
  parameter int DEPTH   = 4,
  parameter bit FIFO_EN = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [TW-1:0] data_i,
  input  logic          pop_i,
  input  logic          clr_ovf_i,
  output logic [TW-1:0] head_o,
  output logic          valid_o,
  output logic          full_o,
  output logic          acc_o,
  output logic          ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  if (FIFO_EN) begin : g_fifo
    logic [TW-1:0] mem_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          do_push, do_pop;

    assign full_o  = (cnt_q == FULL_CNT);
    assign valid_o = (cnt_q != '0);
    assign do_pop  = pop_i & valid_o;
    assign do_push = push_i & (~full_o | do_pop);
    assign acc_o   = do_push;
    assign head_o  = mem_q[rp_q];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wp_q  <= '0;
        rp_q  <= '0;
        cnt_q <= '0;
        ovf_o <= 1'b0;
      end else begin
        if (do_push) wp_q <= (wp_q == LAST_PTR) ? '0 : wp_q + 1'b1;
        if (do_pop)  rp_q <= (rp_q == LAST_PTR) ? '0 : rp_q + 1'b1;
        case ({do_push, do_pop})
          2'b10:   cnt_q <= cnt_q + 1'b1;
          2'b01:   cnt_q <= cnt_q - 1'b1;
          default: cnt_q <= cnt_q;
        endcase
        if (push_i & ~do_push) ovf_o <= 1'b1;
        else if (clr_ovf_i)    ovf_o <= 1'b0;
      end
    end

    always_ff @(posedge clk_i) begin
      if (do_push) mem_q[wp_q] <= data_i;
    end
  end else begin : g_single
    logic [TW-1:0] data_q;
    logic          vld_q;

    assign head_o  = data_q;
    assign valid_o = vld_q;
    assign full_o  = 1'b0;
    assign acc_o   = push_i;
    assign ovf_o   = 1'b0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q <= '0;
        vld_q  <= 1'b0;
      end else if (push_i) begin
        data_q <= data_i;
        vld_q  <= 1'b1;
      end else if (pop_i) begin
        vld_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tsc_evt.sv
module tsc_evt #(
  parameter int NEVT = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NEVT-1:0] set_i,
  input  logic [NEVT-1:0] w1c_i,
  input  logic [NEVT-1:0] arm_i,
  input  logic            mask_we_i,
  input  logic [NEVT-1:0] mask_wd_i,
  output logic [NEVT-1:0] evt_o,
  output logic [NEVT-1:0] mask_o,
  output logic            irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_o  <= '0;
      mask_o <= '0;
    end else begin
      // arm drops stale events, new events still win
      evt_o  <= (evt_o & ~(w1c_i | arm_i)) | set_i;
      mask_o <= (mask_we_i ? mask_wd_i : mask_o) | arm_i;
    end
  end

  assign irq_o = |(evt_o & mask_o);
endmodule

// File: rtl/tsc_capture_top.sv
module tsc_capture_top
  import tsc_pkg::*;
#(
  parameter int TW          = 64,
  parameter int DW          = 32,
  parameter int DEPTH       = 4,
  parameter bit FIFO_EN     = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] time_i,
  input  logic [1:0]    trig_i,
  input  logic          pps_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic          wr, rd;
  logic [NCH-1:0] cap_rise, cap_acc, fifo_pop, fifo_full, fifo_valid, ovf, clr_ovf;
  logic [TW-1:0]  head [NCH];
  logic [NEVT-1:0] evt, mask, evt_set;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [2:0] HI_ADDR = 3'(A_C0_HI + 2*c);

    tsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(trig_i[c]),
      .rise_o (cap_rise[c])
    );

    assign fifo_pop[c] = rd & (addr_i == HI_ADDR);
    assign clr_ovf[c]  = wr & (addr_i == A_STAT) & wdata_i[STAT_OVF_LSB+c];

    tsc_store #(.TW(TW), .DEPTH(DEPTH), .FIFO_EN(FIFO_EN)) u_store (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .push_i   (cap_rise[c]),
      .data_i   (time_i),
      .pop_i    (fifo_pop[c]),
      .clr_ovf_i(clr_ovf[c]),
      .head_o   (head[c]),
      .valid_o  (fifo_valid[c]),
      .full_o   (fifo_full[c]),
      .acc_o    (cap_acc[c]),
      .ovf_o    (ovf[c])
    );
  end

  assign evt_set = {pps_i, cap_acc};

  tsc_evt #(.NEVT(NEVT)) u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (evt_set),
    .w1c_i    ((wr && addr_i == A_EVT) ? wdata_i[NEVT-1:0] : '0),
    .arm_i    ((wr && addr_i == A_ARM) ? wdata_i[NEVT-1:0] : '0),
    .mask_we_i(wr && addr_i == A_MASK),
    .mask_wd_i(wdata_i[NEVT-1:0]),
    .evt_o    (evt),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_EVT:   rd_mux = DW'(evt);
      A_MASK:  rd_mux = DW'(mask);
      A_STAT:  rd_mux = DW'({ovf, 2'b00, fifo_valid});
      A_C0_LO: rd_mux = head[0][DW-1:0];
      A_C0_HI: rd_mux = head[0][TW-1:DW];
      A_C1_LO: rd_mux = head[1][DW-1:0];
      A_C1_HI: rd_mux = head[1][TW-1:DW];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd ? rd_mux : '0;
  end
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter bit FIFO_EN = 1'b1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pps_i,
  input logic       req_i,
  input logic       we_i,
  input logic [2:0] addr_i,
  input logic [2:0] wdata_lo,
  input logic       irq_o,
  input logic [1:0] cap_rise,
  input logic [1:0] cap_acc,
  input logic [1:0] fifo_full,
  input logic [1:0] fifo_pop,
  input logic [1:0] fifo_valid,
  input logic [1:0] ovf,
  input logic [2:0] evt,
  input logic [2:0] mask
);
  p_clear_all_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 3'd0 && wdata_lo == 3'b111 && cap_acc == 2'b00 && !pps_i)
    |=> !irq_o);

  p_arm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 3'd3 && wdata_lo[0] && !cap_acc[0])
    |=> (!evt[0] && mask[0]));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (FIFO_EN && cap_rise[0] && fifo_full[0] && !fifo_pop[0]) |=> ovf[0]);

  p_valid_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fifo_valid[1]) |-> $past(cap_rise[1]));

  p_pps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pps_i |=> evt[2]);

  p_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !FIFO_EN |-> (ovf == 2'b00));
endmodule

bind tsc_capture_top tsc_checker #(.FIFO_EN(FIFO_EN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pps_i     (pps_i),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_lo  (wdata_i[2:0]),
  .irq_o     (irq_o),
  .cap_rise  (cap_rise),
  .cap_acc   (cap_acc),
  .fifo_full (fifo_full),
  .fifo_pop  (fifo_pop),
  .fifo_valid(fifo_valid),
  .ovf       (ovf),
  .evt       (evt),
  .mask      (mask)
);

// File: tb/tb_tsc_capture_top.sv
module tb_tsc_capture_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_v = '0;
  logic [1:0]  trig = '0;
  logic        pps = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_s;
  logic        irq, irq_s;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tsc_capture_top dut (
    .clk_i(clk), .rst_ni(rst_n), .time_i(time_v), .trig_i(trig), .pps_i(pps),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq));

  tsc_capture_top #(.FIFO_EN(1'b0)) dut_s (
    .clk_i(clk), .rst_ni(rst_n), .time_i(time_v), .trig_i(trig), .pps_i(pps),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata_s), .irq_o(irq_s));

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d, output logic [31:0] ds);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata; ds = rdata_s;
  endtask

  task automatic fire(input int c, input logic [63:0] t);
    @(negedge clk); time_v = t; trig[c] = 1'b1;
    repeat (6) @(negedge clk);
    trig[c] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d, ds;
    chk("R1 irq", irq, 0);
    chk("R11 idle rdata", rdata, 0);
    rd(3'd0, d, ds); chk("R1 evt", d, 0);
    rd(3'd1, d, ds); chk("R1 mask", d, 0);
    rd(3'd2, d, ds); chk("R1 stat", d, 0);
    @(negedge clk); chk("R11 rdata after no read", rdata, 0);
  endtask

  task automatic t_capture_order();
    logic [31:0] d, ds;
    fire(0, 64'h1111_2222_3333_4444);
    // held-high trigger: one capture only
    @(negedge clk); time_v = 64'h5555_6666_7777_8888; trig[0] = 1'b1;
    repeat (20) @(negedge clk); time_v = 64'hdead_beef_0000_0001;
    repeat (5) @(negedge clk); trig[0] = 1'b0; repeat (3) @(negedge clk);
    rd(3'd0, d, ds); chk("R2 evt ch0", d, 32'h1);
    rd(3'd2, d, ds); chk("R5 valid ch0", d, 32'h1);
    rd(3'd4, d, ds); chk("R4 lo first", d, 32'h3333_4444);
    rd(3'd4, d, ds); chk("R4 lo no pop", d, 32'h3333_4444);
    rd(3'd5, d, ds); chk("R4 hi first", d, 32'h1111_2222);
    rd(3'd4, d, ds); chk("R4 lo second", d, 32'h7777_8888);
    rd(3'd5, d, ds); chk("R4 hi second", d, 32'h5555_6666);
    rd(3'd2, d, ds); chk("R2 R5 one capture per edge, empty", d, 32'h0);
    wr(3'd0, 32'h7);
  endtask

  task automatic t_overflow();
    logic [31:0] d, ds;
    for (int i = 0; i < 5; i++) fire(1, {32'h0a00_0000 + i, 32'h0b00_0000 + i});
    rd(3'd2, d, ds); chk("R3 ovf ch1 + valid", d, 32'h22);
    for (int i = 0; i < 4; i++) begin
      rd(3'd6, d, ds); chk("R3 lo order", d, 32'h0b00_0000 + i);
      rd(3'd7, d, ds); chk("R3 hi order", d, 32'h0a00_0000 + i);
    end
    rd(3'd2, d, ds); chk("R3 R5 drained, ovf held", d, 32'h20);
    wr(3'd2, 32'h20);
    rd(3'd2, d, ds); chk("R3 ovf w1c", d, 32'h0);
    wr(3'd0, 32'h7);
  endtask

  task automatic t_pps_irq_w1c();
    logic [31:0] d, ds;
    @(negedge clk); pps = 1; @(negedge clk); pps = 0;
    rd(3'd0, d, ds); chk("R6 pps evt", d, 32'h4);
    chk("R7 masked off", irq, 0);
    wr(3'd1, 32'h4); chk("R7 irq on mask", irq, 1);
    wr(3'd0, 32'h3); chk("R8 w1c other bits keep irq", irq, 1);
    wr(3'd0, 32'h0);
    rd(3'd0, d, ds); chk("R8 write 0 no effect", d, 32'h4);
    // clear coinciding with new pps: set wins
    @(negedge clk); req = 1; we = 1; addr = 3'd0; wdata = 32'h4; pps = 1;
    @(negedge clk); req = 0; we = 0; pps = 0;
    chk("R8 set wins over clear", irq, 1);
    wr(3'd0, 32'h4); chk("R8 cleared irq", irq, 0);
    wr(3'd1, 32'h0);
  endtask

  task automatic t_arm();
    logic [31:0] d, ds;
    fire(0, 64'h0000_00aa_0000_00bb);
    chk("R7 pending masked", irq, 0);
    wr(3'd3, 32'h1);
    chk("R9 arm drops stale", irq, 0);
    rd(3'd0, d, ds); chk("R9 evt cleared", d, 32'h0);
    rd(3'd1, d, ds); chk("R9 mask set", d, 32'h1);
    fire(0, 64'h0000_00cc_0000_00dd);
    chk("R9 R7 new capture irq", irq, 1);
    rd(3'd5, d, ds); rd(3'd5, d, ds);
    chk("R4 second armed capture", d, 32'h0000_00cc);
    wr(3'd0, 32'h7); wr(3'd1, 32'h0);
  endtask

  task automatic t_single();
    logic [31:0] d, ds;
    fire(1, 64'h0000_0101_0000_0001);
    fire(1, 64'h0000_0202_0000_0002);
    rd(3'd2, d, ds); chk("R10 single valid", ds, 32'h2);
    rd(3'd6, d, ds);
    chk("R10 single newest lo", ds, 32'h0000_0002);
    chk("R4 fifo oldest lo", d, 32'h0000_0001);
    rd(3'd7, d, ds); chk("R10 single newest hi", ds, 32'h0000_0202);
    rd(3'd2, d, ds); chk("R10 single valid cleared", ds, 32'h0);
    chk("R5 fifo still valid", d, 32'h2);
    for (int i = 0; i < 6; i++) fire(1, 64'(i));
    rd(3'd2, d, ds); chk("R10 single no overflow", ds, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_capture_order();
    t_overflow();
    t_pps_irq_w1c();
    t_arm();
    t_single();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule